// File: doc/BRIEF.md
# Supply Rail Fault Monitor and Shutdown Latch

This block supervises a multi-rail display power supply. Six undervoltage comparator flags, one per generated rail, are filtered against a microsecond tick so that a rail is only declared faulty after its flag has stayed high for a programmable number of ticks. An accepted rail fault latches a global shutdown request. The latch holds until the enable level is brought low and then high again, or until the input supply leaves undervoltage lockout.

A die over-temperature condition also forces shutdown. It uses a separate hot flag and cool-down flag, so it releases by itself once the die has cooled, without any recycle. The block drives an active-low fault pin, modelled as a level where 0 means the pin is pulled low. It also packs its state into an 8-bit status byte that a register interface can read.

A rail is only watched once the power sequencer reports it as enabled and past soft-start. This keeps a normal power-up ramp from tripping the latch.

Top module: `fault_monitor`

## Requirements
- R1: A rail fault is accepted only on the usTick pulse that completes DEBOUNCE_US consecutive ticks with that rail's flag high. A flag held for DEBOUNCE_US-1 ticks and then dropped leaves no trace.
- R2: A rail whose railArmed bit is 0 never accepts a fault, however long its flag stays high.
- R3: An accepted rail fault sets shutdownReq to 1 and faultPinN to 0 from the next clock. Both keep those values after the rail flag clears.
- R4: The rail latch clears on the first clock at which enLevel is seen high after being low. Holding enLevel low alone does not clear it.
- R5: While uvloFlag is 1, shutdownReq is 1. The latch clears on the first clock at which uvloFlag is seen low after being high.
- R6: otHot high sets shutdownReq to 1 and faultPinN to 0 one clock later. The condition stays after otHot drops and releases one clock after otCool is seen high with otHot low, with no enable recycle.
- R7: Status byte layout: bit 5 negative base rail, bit 4 positive base rail, bit 3 positive source rail, bit 2 negative source rail, bit 1 positive gate rail, bit 0 negative gate rail. Bit i reflects railUvFlag[i], and several bits may be set together.
- R8: Status bit 7 (power-good) is 1 only when every rail is armed, no rail flag is high, no rail fault is latched and over-temperature is not active.
- R9: Status bit 6 reports over-temperature and sets one clock after the over-temperature condition starts. Bits 6..0 stay set after their condition clears, until an enable or lockout recycle.
- R10: After reset, shutdownReq is 0, faultPinN is 1 and every status bit other than power-good is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-clock pulse per microsecond |
| railUvFlag | input | 6 | Per-rail undervoltage comparator flags |
| railArmed | input | 6 | Rail enabled and soft-start done |
| otHot | input | 1 | Die above trip temperature |
| otCool | input | 1 | Die cooled past hysteresis |
| enLevel | input | 1 | Enable level |
| uvloFlag | input | 1 | Input supply in lockout |
| shutdownReq | output | 1 | Global shutdown request |
| faultPinN | output | 1 | Active-low fault pin (0 = pulled low) |
| statusByte | output | 8 | Packed status for register read |

## Verification
The debounce is probed with a flag held one tick short of the window and one held for the full window, which separates an off-by-one counter from a correct one. A disarmed rail with a long flag separates arming from plain filtering. Each rail is faulted in turn, and then two rails together, which pins down every status bit position.

Recovery is tried through an enable pulse, through enable held low only, and through a lockout pass, to show which events clear the latch. An over-temperature episode with the hot flag dropped before the cool flag rises separates real hysteresis from a plain level follower.

// File: rtl/fault_mon_pkg.sv
package fault_mon_pkg;

  typedef struct packed {
    logic clearLatch;
    logic otActive;
  } monStrobes_t;

  typedef enum logic {
    OT_NORMAL = 1'b0,
    OT_HOT    = 1'b1
  } otState_t;

endpackage

// File: rtl/fault_mon_ctrl.sv
module fault_mon_ctrl
  import fault_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enLevel,
  input  logic        uvloFlag,
  input  logic        otHot,
  input  logic        otCool,
  input  logic        railLatch,
  output monStrobes_t strb,
  output logic        shutdownReq,
  output logic        faultPinN
);

  otState_t otState;
  logic     enPrev;
  logic     uvloPrev;
  logic     enRise;
  logic     uvloExit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      uvloPrev <= 1'b0;
    end else begin
      enPrev   <= enLevel;
      uvloPrev <= uvloFlag;
    end
  end

  assign enRise   = enLevel & ~enPrev;
  assign uvloExit = ~uvloFlag & uvloPrev;

  // Thermal hysteresis: hot trips, only the cool flag releases.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otState <= OT_NORMAL;
    end else begin
      unique case (otState)
        OT_NORMAL: if (otHot) otState <= OT_HOT;
        OT_HOT:    if (!otHot && otCool) otState <= OT_NORMAL;
        default:   otState <= OT_NORMAL;
      endcase
    end
  end

  always_comb begin
    strb.clearLatch = enRise | uvloExit;
    strb.otActive   = (otState == OT_HOT);
  end

  assign shutdownReq = railLatch | strb.otActive | uvloFlag;
  assign faultPinN   = ~(railLatch | strb.otActive);

  // R6: a hot flag forces shutdown and pulls the pin on the next clock
  p_ot_trip_r6: assert property (@(posedge clk) disable iff (!rstN)
    otHot |=> (shutdownReq && !faultPinN));

  // R6: no release without the cool flag
  p_ot_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.otActive && !otCool) |=> shutdownReq);

  // R4: an enable rising edge empties the rail latch
  p_en_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enLevel) |=> !railLatch);

  // R5: lockout always requests shutdown
  p_uvlo_shdn_r5: assert property (@(posedge clk) disable iff (!rstN)
    uvloFlag |-> shutdownReq);

endmodule

// File: rtl/fault_mon_dp.sv
module fault_mon_dp
  import fault_mon_pkg::*;
#(
  parameter int RAIL_COUNT  = 6,
  parameter int DEBOUNCE_US = 250
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  usTick,
  input  logic [RAIL_COUNT-1:0] railUvFlag,
  input  logic [RAIL_COUNT-1:0] railArmed,
  input  monStrobes_t           strb,
  output logic                  railLatch,
  output logic [RAIL_COUNT+1:0] statusByte
);

  localparam int CNT_W  = $clog2(DEBOUNCE_US + 1);
  localparam int PG_BIT = RAIL_COUNT + 1;
  localparam int OT_BIT = RAIL_COUNT;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEBOUNCE_US - 1);

  logic [RAIL_COUNT-1:0] stickyQ;
  logic [RAIL_COUNT-1:0] acceptNow;
  logic                  otSticky;
  logic                  powerGood;

  for (genvar i = 0; i < RAIL_COUNT; i++) begin : g_rail
    logic [CNT_W-1:0] cnt;
    logic             watching;

    assign watching     = railArmed[i] & railUvFlag[i];
    assign acceptNow[i] = watching & usTick & (cnt == LAST_CNT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (!watching || strb.clearLatch) begin
        cnt <= '0;
      end else if (usTick && cnt != LAST_CNT) begin
        cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stickyQ[i] <= 1'b0;
      end else if (strb.clearLatch) begin
        stickyQ[i] <= 1'b0;
      end else if (acceptNow[i]) begin
        stickyQ[i] <= 1'b1;
      end
    end

    // R2: a rail can only latch while armed and flagging
    p_accept_armed_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stickyQ[i]) |-> $past(railArmed[i] && railUvFlag[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otSticky <= 1'b0;
    end else if (strb.clearLatch) begin
      otSticky <= 1'b0;
    end else if (strb.otActive) begin
      otSticky <= 1'b1;
    end
  end

  assign railLatch = |stickyQ;
  assign powerGood = (&railArmed) & ~(|railUvFlag) & ~railLatch & ~strb.otActive;

  always_comb begin
    statusByte                   = '0;
    statusByte[RAIL_COUNT-1:0]   = stickyQ;
    statusByte[OT_BIT]           = otSticky;
    statusByte[PG_BIT]           = powerGood;
  end

  // R3: latched rail bits persist until a recycle strobe
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearLatch |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  // R8: power-good never coexists with a latched rail bit
  p_pgood_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[PG_BIT] |-> (statusByte[RAIL_COUNT-1:0] == '0));

endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
  import fault_mon_pkg::*;
#(
  parameter int RAIL_COUNT  = 6,
  parameter int DEBOUNCE_US = 250
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  usTick,
  input  logic [RAIL_COUNT-1:0] railUvFlag,
  input  logic [RAIL_COUNT-1:0] railArmed,
  input  logic                  otHot,
  input  logic                  otCool,
  input  logic                  enLevel,
  input  logic                  uvloFlag,
  output logic                  shutdownReq,
  output logic                  faultPinN,
  output logic [RAIL_COUNT+1:0] statusByte
);

  monStrobes_t strb;
  logic        railLatch;

  fault_mon_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enLevel    (enLevel),
    .uvloFlag   (uvloFlag),
    .otHot      (otHot),
    .otCool     (otCool),
    .railLatch  (railLatch),
    .strb       (strb),
    .shutdownReq(shutdownReq),
    .faultPinN  (faultPinN)
  );

  fault_mon_dp #(
    .RAIL_COUNT (RAIL_COUNT),
    .DEBOUNCE_US(DEBOUNCE_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .usTick    (usTick),
    .railUvFlag(railUvFlag),
    .railArmed (railArmed),
    .strb      (strb),
    .railLatch (railLatch),
    .statusByte(statusByte)
  );

endmodule

// File: tb/fault_monitor_tb.sv
module fault_monitor_tb;

  localparam int DEB = 250;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic [5:0] railUvFlag = '0;
  logic [5:0] railArmed = '0;
  logic       otHot = 1'b0;
  logic       otCool = 1'b0;
  logic       enLevel = 1'b0;
  logic       uvloFlag = 1'b0;
  logic       shutdownReq;
  logic       faultPinN;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic       sd;
    logic       pin;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  event checkEv;

  always #10 clk = ~clk;

  fault_monitor #(.RAIL_COUNT(6), .DEBOUNCE_US(DEB)) u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .railUvFlag(railUvFlag),
    .railArmed(railArmed), .otHot(otHot), .otCool(otCool), .enLevel(enLevel),
    .uvloFlag(uvloFlag), .shutdownReq(shutdownReq), .faultPinN(faultPinN),
    .statusByte(statusByte)
  );

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(checkEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (statusByte !== e.st || shutdownReq !== e.sd || faultPinN !== e.pin) begin
          failures++;
          $display("FAIL %s: status=%h sd=%b pin=%b expected status=%h sd=%b pin=%b",
                   e.tag, statusByte, shutdownReq, faultPinN, e.st, e.sd, e.pin);
        end
      end
    end
  end

  task automatic expectOut(input logic [7:0] st, input logic sd, input logic pin, input string tag);
    expItem_t e;
    e.st = st; e.sd = sd; e.pin = pin; e.tag = tag;
    expQ.push_back(e);
    ->checkEv;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) usTick = 1'b1;
      @(negedge clk) usTick = 1'b0;
    end
  endtask

  task automatic recycleEn();
    enLevel = 1'b0;
    idle(2);
    enLevel = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    expectOut(8'h00, 1'b0, 1'b1, "R10 reset state");

    enLevel = 1'b1;
    railArmed = 6'h3f;
    idle(2);
    expectOut(8'h80, 1'b0, 1'b1, "R8 power-good all armed");

    // R1: one tick short of the window
    railUvFlag[3] = 1'b1;
    idle(1);
    expectOut(8'h00, 1'b0, 1'b1, "R8 pgood drops on live flag");
    ticks(DEB - 1);
    railUvFlag = '0;
    idle(1);
    expectOut(8'h80, 1'b0, 1'b1, "R1 short pulse ignored");

    // R2: disarmed rail
    railArmed[2] = 1'b0;
    railUvFlag[2] = 1'b1;
    ticks(DEB + 50);
    expectOut(8'h00, 1'b0, 1'b1, "R2 disarmed rail ignored");
    railUvFlag = '0;
    railArmed = 6'h3f;
    idle(1);
    expectOut(8'h80, 1'b0, 1'b1, "R2 no latched bit after rearm");

    // R1/R3: full window
    railUvFlag[4] = 1'b1;
    ticks(DEB);
    expectOut(8'h10, 1'b1, 1'b0, "R1 R3 accepted at full window");
    railUvFlag = '0;
    idle(5);
    expectOut(8'h10, 1'b1, 1'b0, "R3 R9 latch holds after flag clears");

    // R4: enable low alone keeps latch
    enLevel = 1'b0;
    idle(4);
    expectOut(8'h10, 1'b1, 1'b0, "R4 enable low alone does not clear");
    enLevel = 1'b1;
    idle(2);
    expectOut(8'h80, 1'b0, 1'b1, "R4 enable rise clears");

    // R7: two rails together, then R5 lockout recycle
    railUvFlag = 6'b100001;
    ticks(DEB);
    railUvFlag = '0;
    expectOut(8'h21, 1'b1, 1'b0, "R7 two rails together");
    uvloFlag = 1'b1;
    idle(2);
    expectOut(8'h21, 1'b1, 1'b0, "R5 latch kept during lockout");
    uvloFlag = 1'b0;
    idle(2);
    expectOut(8'h80, 1'b0, 1'b1, "R5 lockout exit clears");
    uvloFlag = 1'b1;
    idle(1);
    expectOut(8'h80, 1'b1, 1'b1, "R5 lockout requests shutdown");
    uvloFlag = 1'b0;
    idle(2);
    expectOut(8'h80, 1'b0, 1'b1, "R5 shutdown released after lockout");

    // R6/R9: thermal hysteresis
    otHot = 1'b1;
    idle(1);
    expectOut(8'h00, 1'b1, 1'b0, "R6 hot trips next clock");
    idle(1);
    expectOut(8'h40, 1'b1, 1'b0, "R9 over-temperature bit set");
    otHot = 1'b0;
    idle(3);
    expectOut(8'h40, 1'b1, 1'b0, "R6 holds until cool flag");
    otCool = 1'b1;
    idle(1);
    expectOut(8'hc0, 1'b0, 1'b1, "R6 R9 auto release, bit sticky");
    otCool = 1'b0;
    recycleEn();
    expectOut(8'h80, 1'b0, 1'b1, "R9 recycle clears over-temperature bit");

    // R7: each rail bit position
    for (int i = 0; i < 6; i++) begin
      railUvFlag = 6'(1 << i);
      ticks(DEB);
      railUvFlag = '0;
      expectOut(8'(1 << i), 1'b1, 1'b0, $sformatf("R7 rail bit %0d", i));
      recycleEn();
      expectOut(8'h80, 1'b0, 1'b1, $sformatf("R4 clear after rail %0d", i));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule